// File: doc/BRIEF.md
# DPLL Operating Mode Controller

This block chooses what frequency word steers the digitally controlled oscillator of a telecom clock DPLL, and which parts of the loop run. It supports four operating modes. In normal mode the oscillator follows the filtered, slope-limited phase error. In fast lock the same path runs with the slope limiter bypassed, so acquisition is quicker. In holdover the oscillator runs from a frequency word stored earlier. In freerun it runs with zero offset, so it follows the master clock alone.

Mode requests and the reference-rate code are sampled only on a frame tick. While the loop runs in normal mode, a running average of the loop-filter word is kept on every frame tick. That average becomes the holdover word.

The lock flag needs two things. The loop-filter word must stay inside a programmable magnitude window for a set number of consecutive frame ticks. The slope limiter must also not be clamping. The block also republishes the applied 2-bit reference code and a flag that picks a 1.544 MHz auxiliary clock instead of 2.048 MHz.

Top module: `dpll_mode_ctrl`

## Requirements
- R1: Mode codes are 00 freerun, 01 holdover, 10 normal and 11 fast lock. `cur_mode` takes the value of `mode_req` only at a clock edge where `frame_tick` is 1, and holds its value otherwise.
- R2: `pd_en` is 1 in normal and fast lock and 0 in freerun and holdover. `lim_en` is 1 only in normal mode.
- R3: In normal and fast lock modes, `dco_word` equals `lf_word` in the same cycle.
- R4: In freerun, `dco_word` is 0 whatever `lf_word` is.
- R5: In holdover, `dco_word` equals the stored holdover word, and changes to `lf_word` have no effect on it.
- R6: The holdover word H is updated at a clock edge only when all three hold: `frame_tick` is 1, `cur_mode` is normal, and `mode_req` is normal. The update is H <= H + floor((lf_word - H) / 2^AVG_SHIFT). As a result, the tick on which the mode leaves normal does not update H, and no update happens in any other mode.
- R7: A counter runs while `pd_en` is 1 and is cleared whenever `pd_en` is 0. On each frame tick it increments, saturating at LOCK_TICKS, if |lf_word| <= `lock_thr`; otherwise that tick clears it. `lock` is 1 when the counter has reached LOCK_TICKS, `pd_en` is 1, and it is not the case that both `lim_en` and `lim_active` are 1.
- R8: `ref_cfg` takes the value of `ref_sel` at a frame tick. The codes are 00 = 19.44 MHz, 01 = 8 kHz, 10 = 1.544 MHz and 11 = 2.048 MHz. `aux_t1_sel` is 1 exactly when `ref_cfg` is 10.
- R9: A synchronous active-high `rst` forces freerun, clears the holdover word and the lock counter, and sets `ref_cfg` to 00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| frame_tick | input | 1 | Frame tick; the edge at which mode and reference changes are applied |
| mode_req | input | 2 | Requested mode |
| ref_sel | input | 2 | Requested reference-rate code |
| lf_word | input | WORD_W | Signed loop-filter frequency word |
| lim_active | input | 1 | Slope limiter is clamping |
| lock_thr | input | WORD_W | Unsigned magnitude window for lock |
| dco_word | output | WORD_W | Signed frequency word to the oscillator |
| pd_en | output | 1 | Phase detector enable |
| lim_en | output | 1 | Slope limiter enable |
| lock | output | 1 | Lock indication |
| cur_mode | output | 2 | Applied mode |
| ref_cfg | output | 2 | Applied reference-rate code |
| aux_t1_sel | output | 1 | Auxiliary clock is 1.544 MHz when 1, 2.048 MHz when 0 |

## Verification
The bench builds the block with WORD_W=16, AVG_SHIFT=2 and LOCK_TICKS=4. With a four-tick lock window, lock can be gained, lost and regained many times within a few thousand cycles. With a shift of 2, the holdover average settles visibly after a handful of ticks, so a frozen word can be told apart from a still-moving one. Because the word is 16 bits, the most negative loop word can be driven, which exercises the magnitude compare at its edge.

// File: rtl/dpll_mode_pkg.sv
package dpll_mode_pkg;

    typedef enum logic [1:0] {
        MODE_FREE = 2'b00,
        MODE_HOLD = 2'b01,
        MODE_NORM = 2'b10,
        MODE_FAST = 2'b11
    } dpll_mode_e;

    typedef enum logic [1:0] {
        REF_19M44 = 2'b00,
        REF_8K    = 2'b01,
        REF_1M544 = 2'b10,
        REF_2M048 = 2'b11
    } ref_code_e;

    typedef struct packed {
        logic pd_en;
        logic lim_en;
    } path_en_t;

    function automatic path_en_t mode_enables(dpll_mode_e m);
        path_en_t e;
        e.pd_en  = (m == MODE_NORM) || (m == MODE_FAST);
        e.lim_en = (m == MODE_NORM);
        return e;
    endfunction

    function automatic logic aux_is_t1(ref_code_e r);
        return (r == REF_1M544);
    endfunction

endpackage

// File: rtl/dpll_mode_seq.sv
module dpll_mode_seq
    import dpll_mode_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       frame_tick,
    input  logic [1:0] mode_req,
    input  logic [1:0] ref_sel,
    output dpll_mode_e mode_q,
    output ref_code_e  ref_q,
    output path_en_t   path_en,
    output logic       hold_upd
);

    dpll_mode_e req_mode;

    always_comb begin
        req_mode = dpll_mode_e'(mode_req);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            mode_q <= MODE_FREE;
            ref_q  <= REF_19M44;
        end else if (frame_tick) begin
            mode_q <= req_mode;
            ref_q  <= ref_code_e'(ref_sel);
        end
    end

    always_comb begin
        path_en  = mode_enables(mode_q);
        // averaging runs only on ticks that keep the loop in normal mode
        hold_upd = frame_tick && (mode_q == MODE_NORM) && (req_mode == MODE_NORM);
    end

endmodule

// File: rtl/dpll_hold_store.sv
module dpll_hold_store #(
    parameter int WORD_W    = 24,
    parameter int AVG_SHIFT = 4
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     upd_en,
    input  logic signed [WORD_W-1:0] lf_word,
    output logic signed [WORD_W-1:0] hold_word
);

    localparam int EXT_W = WORD_W + 1;

    logic signed [EXT_W-1:0] diff;
    logic signed [EXT_W-1:0] step;
    logic signed [EXT_W-1:0] nxt;

    always_comb begin
        diff = EXT_W'(lf_word) - EXT_W'(hold_word);
        step = diff >>> AVG_SHIFT;
        nxt  = EXT_W'(hold_word) + step;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            hold_word <= '0;
        end else if (upd_en) begin
            hold_word <= nxt[WORD_W-1:0];
        end
    end

endmodule

// File: rtl/dpll_lock_det.sv
module dpll_lock_det #(
    parameter int WORD_W     = 24,
    parameter int LOCK_TICKS = 16
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     frame_tick,
    input  logic                     track_en,
    input  logic signed [WORD_W-1:0] lf_word,
    input  logic        [WORD_W-1:0] lock_thr,
    output logic                     count_full
);

    localparam int CNT_W = $clog2(LOCK_TICKS + 1);
    localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(LOCK_TICKS);

    logic [CNT_W-1:0] cnt;
    logic [WORD_W:0]  mag;
    logic             in_win;

    always_comb begin
        if (lf_word[WORD_W-1]) begin
            mag = (WORD_W+1)'(0) - {lf_word[WORD_W-1], lf_word};
        end else begin
            mag = {1'b0, lf_word};
        end
        in_win = (mag <= {1'b0, lock_thr});
    end

    always_ff @(posedge clk) begin
        if (rst || !track_en) begin
            cnt <= '0;
        end else if (frame_tick) begin
            if (!in_win) begin
                cnt <= '0;
            end else if (cnt != CNT_MAX) begin
                cnt <= cnt + 1'b1;
            end
        end
    end

    assign count_full = (cnt == CNT_MAX);

endmodule

// File: rtl/dpll_mode_ctrl.sv
module dpll_mode_ctrl
    import dpll_mode_pkg::*;
#(
    parameter int WORD_W     = 24,
    parameter int AVG_SHIFT  = 4,
    parameter int LOCK_TICKS = 16
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     frame_tick,
    input  logic [1:0]               mode_req,
    input  logic [1:0]               ref_sel,
    input  logic signed [WORD_W-1:0] lf_word,
    input  logic                     lim_active,
    input  logic        [WORD_W-1:0] lock_thr,
    output logic signed [WORD_W-1:0] dco_word,
    output logic                     pd_en,
    output logic                     lim_en,
    output logic                     lock,
    output logic [1:0]               cur_mode,
    output logic [1:0]               ref_cfg,
    output logic                     aux_t1_sel
);

    dpll_mode_e               mode_q;
    ref_code_e                ref_q;
    path_en_t                 path_en;
    logic                     hold_upd;
    logic signed [WORD_W-1:0] hold_word;
    logic                     count_full;

    dpll_mode_seq u_seq (
        .clk        (clk),
        .rst        (rst),
        .frame_tick (frame_tick),
        .mode_req   (mode_req),
        .ref_sel    (ref_sel),
        .mode_q     (mode_q),
        .ref_q      (ref_q),
        .path_en    (path_en),
        .hold_upd   (hold_upd)
    );

    dpll_hold_store #(
        .WORD_W    (WORD_W),
        .AVG_SHIFT (AVG_SHIFT)
    ) u_hold (
        .clk       (clk),
        .rst       (rst),
        .upd_en    (hold_upd),
        .lf_word   (lf_word),
        .hold_word (hold_word)
    );

    dpll_lock_det #(
        .WORD_W     (WORD_W),
        .LOCK_TICKS (LOCK_TICKS)
    ) u_lock (
        .clk        (clk),
        .rst        (rst),
        .frame_tick (frame_tick),
        .track_en   (path_en.pd_en),
        .lf_word    (lf_word),
        .lock_thr   (lock_thr),
        .count_full (count_full)
    );

    always_comb begin
        unique case (mode_q)
            MODE_NORM, MODE_FAST: dco_word = lf_word;
            MODE_HOLD:            dco_word = hold_word;
            default:              dco_word = '0;
        endcase
    end

    always_comb begin
        pd_en      = path_en.pd_en;
        lim_en     = path_en.lim_en;
        lock       = path_en.pd_en && count_full && !(path_en.lim_en && lim_active);
        cur_mode   = mode_q;
        ref_cfg    = ref_q;
        aux_t1_sel = aux_is_t1(ref_q);
    end

endmodule

// File: rtl/dpll_mode_ctrl_chk.sv
module dpll_mode_ctrl_chk #(
    parameter int WORD_W = 24
) (
    input logic                     clk,
    input logic                     rst,
    input logic                     frame_tick,
    input logic                     lim_active,
    input logic signed [WORD_W-1:0] dco_word,
    input logic                     pd_en,
    input logic                     lim_en,
    input logic                     lock,
    input logic [1:0]               cur_mode
);

    // R1: the applied mode only moves on a frame tick
    a_r1_mode_on_tick: assert property (@(posedge clk) disable iff (rst)
        !frame_tick |=> $stable(cur_mode));

    // R2: freerun and holdover shut the detector and limiter off
    a_r2_paths_off: assert property (@(posedge clk) disable iff (rst)
        (cur_mode == 2'b00 || cur_mode == 2'b01) |-> (!pd_en && !lim_en));

    // R4: freerun drives a zero offset word
    a_r4_freerun_zero: assert property (@(posedge clk) disable iff (rst)
        (cur_mode == 2'b00) |-> (dco_word == '0));

    // R5: stored word is steady while holdover persists
    a_r5_hold_steady: assert property (@(posedge clk) disable iff (rst)
        (cur_mode == 2'b01 && !frame_tick) |=> $stable(dco_word));

    // R7: no lock while the limiter is enabled and clamping
    a_r7_no_lock_clamped: assert property (@(posedge clk) disable iff (rst)
        (lim_en && lim_active) |-> !lock);

    // R7: lock implies the tracking path is running
    a_r7_lock_tracking: assert property (@(posedge clk) disable iff (rst)
        lock |-> pd_en);

endmodule

bind dpll_mode_ctrl dpll_mode_ctrl_chk #(.WORD_W(WORD_W)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .frame_tick (frame_tick),
    .lim_active (lim_active),
    .dco_word   (dco_word),
    .pd_en      (pd_en),
    .lim_en     (lim_en),
    .lock       (lock),
    .cur_mode   (cur_mode)
);

// File: tb/dpll_mode_ctrl_bench.sv
module dpll_mode_ctrl_bench;

    localparam int W  = 16;
    localparam int SH = 2;
    localparam int NT = 4;

    logic                clk = 1'b0;
    logic                rst = 1'b1;
    logic                frame_tick = 1'b0;
    logic [1:0]          mode_req = 2'b00;
    logic [1:0]          ref_sel = 2'b00;
    logic signed [W-1:0] lf_word = '0;
    logic                lim_active = 1'b0;
    logic [W-1:0]        lock_thr = 16'd50;
    logic signed [W-1:0] dco_word;
    logic                pd_en, lim_en, lock, aux_t1_sel;
    logic [1:0]          cur_mode, ref_cfg;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    int     m_mode = 0;
    int     m_ref  = 0;
    int     m_cnt  = 0;
    longint m_hold = 0;

    always #4 clk = ~clk;

    dpll_mode_ctrl #(.WORD_W(W), .AVG_SHIFT(SH), .LOCK_TICKS(NT)) u_dpll_mode_ctrl (
        .clk(clk), .rst(rst), .frame_tick(frame_tick), .mode_req(mode_req),
        .ref_sel(ref_sel), .lf_word(lf_word), .lim_active(lim_active),
        .lock_thr(lock_thr), .dco_word(dco_word), .pd_en(pd_en), .lim_en(lim_en),
        .lock(lock), .cur_mode(cur_mode), .ref_cfg(ref_cfg), .aux_t1_sel(aux_t1_sel)
    );

    task automatic check(input bit ok, input string req, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
        end
    endtask

    function automatic bit m_pd(int m);
        return (m == 2) || (m == 3);
    endfunction

    function automatic longint exp_dco();
        if (m_pd(m_mode)) return longint'(lf_word);
        if (m_mode == 1)  return m_hold;
        return 0;
    endfunction

    function automatic bit exp_lock();
        return m_pd(m_mode) && (m_cnt >= NT) && !((m_mode == 2) && lim_active);
    endfunction

    function automatic longint lf_mag();
        longint v = longint'(lf_word);
        return (v < 0) ? -v : v;
    endfunction

    task automatic check_outputs();
        string dreq;
        dreq = (m_mode == 0) ? "R4" : (m_mode == 1) ? "R5" : "R3";
        check(longint'(dco_word) == exp_dco(), dreq, longint'(dco_word), exp_dco());
        check(pd_en == m_pd(m_mode) && lim_en == (m_mode == 2), "R2",
              {pd_en, lim_en}, {m_pd(m_mode), (m_mode == 2)});
        check(lock == exp_lock(), "R7", lock, exp_lock());
        check(int'(cur_mode) == m_mode, "R1", cur_mode, m_mode);
        check(int'(ref_cfg) == m_ref && aux_t1_sel == (m_ref == 2), "R8",
              {ref_cfg, aux_t1_sel}, {m_ref[1:0], (m_ref == 2)});
    endtask

    task automatic update_model();
        if (rst) begin
            m_mode = 0; m_ref = 0; m_cnt = 0; m_hold = 0;
        end else begin
            if (!m_pd(m_mode)) m_cnt = 0;
            else if (frame_tick) begin
                if (lf_mag() <= longint'(lock_thr)) m_cnt = (m_cnt < NT) ? m_cnt + 1 : NT;
                else m_cnt = 0;
            end
            if (frame_tick && m_mode == 2 && mode_req == 2'b10) begin
                longint d = longint'(lf_word) - m_hold;
                m_hold = m_hold + (d >>> SH);
            end
            if (frame_tick) begin
                m_mode = int'(mode_req);
                m_ref  = int'(ref_sel);
            end
        end
    endtask

    task automatic cycle();
        #1 check_outputs();
        @(posedge clk);
        update_model();
        @(negedge clk);
    endtask

    task automatic tick_with(input logic [1:0] md, input logic signed [W-1:0] lf);
        frame_tick = 1'b1; mode_req = md; lf_word = lf;
        cycle();
        frame_tick = 1'b0;
    endtask

    initial begin
        #(200000 * 8);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual 0 expected 1 (run did not complete)");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h5EED_0042));
        @(negedge clk);
        cycle();
        cycle();
        rst = 1'b0;
        // R9: reset state
        #1;
        check(cur_mode == 2'b00 && dco_word == 0 && ref_cfg == 2'b00 && !lock,
              "R9", {cur_mode, ref_cfg}, 0);
        @(negedge clk);

        // R1: request without a tick is not applied
        mode_req = 2'b10; lf_word = 16'sd40;
        cycle();
        check(cur_mode == 2'b00, "R1", cur_mode, 0);
        // R4: freerun ignores lf_word
        check(dco_word == 0, "R4", dco_word, 0);

        // enter normal, settle average with a constant word
        tick_with(2'b10, 16'sd40);
        for (int i = 0; i < 6; i++) begin
            tick_with(2'b10, 16'sd40);
            cycle();
        end
        // R7: locked after enough in-window ticks, no clamp
        #1 check(lock == 1'b1, "R7", lock, 1);
        lim_active = 1'b1;
        #1 check(lock == 1'b0, "R7", lock, 0);
        lim_active = 1'b0;
        @(negedge clk);

        // leave normal with a very different word: R6 no update on leaving tick
        tick_with(2'b01, -16'sd2000);
        #1 check(longint'(dco_word) == m_hold, "R6", longint'(dco_word), m_hold);
        // R5: holdover ignores lf_word changes and ticks
        lf_word = 16'sd12345;
        cycle();
        tick_with(2'b01, -16'sd7);
        #1 check(longint'(dco_word) == m_hold, "R5", longint'(dco_word), m_hold);
        @(negedge clk);

        // R7: fast lock ignores limiter clamp; most negative word at the edge
        tick_with(2'b11, 16'sd0);
        lim_active = 1'b1;
        for (int i = 0; i < NT + 1; i++) tick_with(2'b11, 16'sd3);
        #1 check(lock == 1'b1, "R7", lock, 1);
        @(negedge clk);
        lock_thr = 16'h8000;
        tick_with(2'b11, -16'sd32768);
        lock_thr = 16'h7FFF;
        tick_with(2'b11, -16'sd32768);
        #1 check(lock == 1'b0, "R7", lock, 0);
        @(negedge clk);
        lim_active = 1'b0;
        lock_thr = 16'd50;

        // R8: reference code capture
        ref_sel = 2'b10;
        tick_with(2'b11, 16'sd0);
        #1 check(aux_t1_sel == 1'b1 && ref_cfg == 2'b10, "R8", ref_cfg, 2);
        @(negedge clk);

        // random phase
        for (int i = 0; i < 4000; i++) begin
            frame_tick = ($urandom % 4) == 0;
            if (($urandom % 30) == 0) mode_req = 2'($urandom);
            if (($urandom % 20) == 0) ref_sel = 2'($urandom);
            if (($urandom % 8) == 0) lf_word = W'($urandom);
            else lf_word = W'(int'($urandom % 121) - 60);
            lim_active = ($urandom % 10) == 0;
            if (($urandom % 500) == 0) rst = 1'b1;
            else rst = 1'b0;
            cycle();
        end
        rst = 1'b0;

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule